// File: doc/BRIEF.md
# Randomized region remapping controller

This block sits between a memory request port and a wear-limited memory array. The system only ever sees its own block addresses. The controller turns each one into an array address through a small translation table that never reaches a port. Each system address is a region index (upper bits) and a block offset (lower bits). The table holds one entry per region. The array region is the region index XOR the stored entry, so a table that resets to all zeros is already the identity mapping and needs no fill pass.

To spread wear, the controller keeps moving regions. Once a region is chosen for a move, a partner region is drawn from a free-running LFSR, and the two regions exchange their array locations one block offset at a time. After every eighth accepted program write, the request port stalls for one migration step. Each step costs the array one extra read and one extra write. A single internal buffer holds the one block whose data is between locations, and requests to that block are served from the buffer. When the last offset has been exchanged, both table entries are rewritten together. Regions are chosen round-robin, and the next region is picked once the exchange is complete.

Top module: `remap_ctrl`

## Requirements
- R1: After reset, req_ready is high, rsp_valid is low and no array access is issued. Until the first migration step, a request to system address A accesses array address A.
- R2: A read of any system block always returns the data last written to it, including partway through an exchange. This means the system-to-array mapping never lets two system blocks share storage.
- R3: The cycle after the 8th, 16th, 24th, ... accepted write, req_ready is low. After any other accepted request, req_ready is high in the next cycle.
- R4: Each stall of the request port contains exactly one array read and one array write. The only exception is the first stall after reset, which holds exactly one read and no write, because no block is yet waiting in the buffer. The number of stalls equals the number of accepted writes divided by 8, rounded down.
- R5: An accepted read gives rsp_valid exactly one cycle later with its data on rsp_rdata. rsp_valid is never high at any other time.
- R6: Accepted reads do not count toward the write quota, and a run of reads alone never stalls the port.
- R7: The partner region is taken from the low bits of a 16-bit maximal-length LFSR with taps 16, 14, 13 and 11. The LFSR advances every clock and is never zero. A partner equal to the moving region is rejected and the pick is retried. Repeated writes to one system address therefore land in at least 4 different array regions over 12,000 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | RW+OW (7) | System block address: region index in the upper RW bits, offset in the lower OW bits |
| req_wdata | input | DW (8) | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | DW (8) | Read data |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write when high, read when low |
| mem_addr | output | RW+OW (7) | Hidden array block address |
| mem_wdata | output | DW (8) | Array write data |
| mem_rdata | input | DW (8) | Array read data, valid the cycle after a read strobe |

## Verification
The bench first fills the whole space with distinct, address-derived values and reads it all back. This separates a wrong identity mapping, or any aliasing, from a correct one before any migration has happened. It then pounds a single hot address with 12,000 writes, reading it back after each write and sweeping the whole space after every thousand. That pattern catches buffer-routing mistakes at the exchange pointer and half-completed exchanges, and it shows whether the hot block really travels across array regions. A read-only sweep after the port has settled shows that reads never consume the write quota. A monitor counts the array accesses inside every stall window, which tells a correct single read and single write apart from a step that skips or doubles an access.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // Migration sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,     // serving requests
    ST_FETCH_B,  // read partner block at current offset
    ST_PUT_A,    // write partner data into moving region's slot
    ST_PUT_B,    // write buffered block into partner slot
    ST_PICK,     // draw a partner region from the LFSR
    ST_FETCH_A,  // read moving region's next block
    ST_LOAD      // capture that block into the buffer
  } step_e;
endpackage

// File: rtl/remap_lfsr.sv
module remap_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb q_d = {q[W-2:0], ^(q & TAPS)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_d;
  end
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int RW = 4,
  parameter int OW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW+OW-1:0] sys_addr,
  input  logic            active,
  input  logic            ph,
  input  logic [RW-1:0]   pa,
  input  logic [RW-1:0]   pb,
  input  logic [OW-1:0]   ptr,
  input  logic            commit,
  output logic [RW+OW-1:0] arr_addr,
  output logic            to_buf,
  output logic [RW-1:0]   ta,
  output logic [RW-1:0]   tb
);
  localparam int NREG = 1 << RW;

  logic [RW-1:0] ent_q [NREG];
  logic [RW-1:0] reg_i, tgt;
  logic [OW-1:0] off;

  // Entry holds target XOR region index: all-zero table is the identity.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ent_q[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < NREG; i++) begin
        if (pa == RW'(i))      ent_q[i] <= tb ^ RW'(i);
        else if (pb == RW'(i)) ent_q[i] <= ta ^ RW'(i);
      end
    end
  end

  always_comb begin
    ta     = pa ^ ent_q[pa];
    tb     = pb ^ ent_q[pb];
    reg_i  = sys_addr[RW+OW-1:OW];
    off    = sys_addr[OW-1:0];
    tgt    = reg_i ^ ent_q[reg_i];
    to_buf = 1'b0;
    if (active) begin
      if (reg_i == pa) begin
        if (off == ptr)     to_buf = 1'b1;
        else if (off < ptr) tgt    = tb;
        else                tgt    = ta;
      end else if (reg_i == pb) begin
        tgt = ((off < ptr) || ((off == ptr) && ph)) ? ta : tb;
      end
    end
    arr_addr = {tgt, off};
  end
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int          REGIONS   = 16,
  parameter int          BLOCKS    = 8,
  parameter int          DW        = 8,
  parameter int          QUOTA     = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  output logic                                    req_ready,
  input  logic                                    req_write,
  input  logic [$clog2(REGIONS)+$clog2(BLOCKS)-1:0] req_addr,
  input  logic [DW-1:0]                           req_wdata,
  output logic                                    rsp_valid,
  output logic [DW-1:0]                           rsp_rdata,
  output logic                                    mem_en,
  output logic                                    mem_we,
  output logic [$clog2(REGIONS)+$clog2(BLOCKS)-1:0] mem_addr,
  output logic [DW-1:0]                           mem_wdata,
  input  logic [DW-1:0]                           mem_rdata
);
  localparam int RW = $clog2(REGIONS);
  localparam int OW = $clog2(BLOCKS);
  localparam int AW = RW + OW;
  localparam int CW = $clog2(QUOTA);

  step_e          st_q, st_d;
  logic           due_q, due_d;
  logic [CW-1:0]  wcnt_q, wcnt_d;
  logic           act_q, act_d;
  logic           ph_q, ph_d;
  logic [RW-1:0]  pa_q, pa_d, pb_q, pb_d;
  logic [OW-1:0]  ptr_q, ptr_d;
  logic [DW-1:0]  buf_q, buf_d;
  logic           rsp_v_q, rsp_buf_q;
  logic [15:0]    lfsr_q;
  logic [AW-1:0]  req_arr;
  logic           hit_buf, commit, acc;
  logic [RW-1:0]  ta, tb;

  remap_lfsr #(.W(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .q(lfsr_q)
  );

  remap_xlate #(.RW(RW), .OW(OW)) u_xlate (
    .clk(clk), .rst_n(rst_n), .sys_addr(req_addr), .active(act_q), .ph(ph_q),
    .pa(pa_q), .pb(pb_q), .ptr(ptr_q), .commit(commit),
    .arr_addr(req_arr), .to_buf(hit_buf), .ta(ta), .tb(tb)
  );

  assign req_ready = (st_q == ST_IDLE) && !due_q;
  assign acc       = req_valid && req_ready;
  assign commit    = (st_q == ST_PUT_B) && (ptr_q == OW'(BLOCKS - 1));
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_buf_q ? buf_q : mem_rdata;

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    due_d  = due_q;
    wcnt_d = wcnt_q;
    act_d  = act_q;
    ph_d   = ph_q;
    pa_d   = pa_q;
    pb_d   = pb_q;
    ptr_d  = ptr_q;
    buf_d  = buf_q;
    if (acc && req_write) begin
      wcnt_d = wcnt_q + 1'b1;
      if (wcnt_q == CW'(QUOTA - 1)) due_d = 1'b1;
      if (hit_buf) buf_d = req_wdata;
    end
    unique case (st_q)
      ST_IDLE: if (due_q) begin
        due_d = 1'b0;
        st_d  = !act_q ? ST_PICK : (ph_q ? ST_PUT_B : ST_FETCH_B);
      end
      ST_FETCH_B: st_d = ST_PUT_A;
      ST_PUT_A: begin
        ph_d = 1'b1;
        st_d = ST_IDLE;
      end
      ST_PUT_B: begin
        if (commit) begin
          pa_d = pa_q + 1'b1;
          st_d = ST_PICK;
        end else begin
          ptr_d = ptr_q + 1'b1;
          st_d  = ST_FETCH_A;
        end
      end
      ST_PICK: if (lfsr_q[RW-1:0] != pa_q) begin
        pb_d  = lfsr_q[RW-1:0];
        ptr_d = '0;
        st_d  = ST_FETCH_A;
      end
      ST_FETCH_A: st_d = ST_LOAD;
      ST_LOAD: begin
        buf_d = mem_rdata;
        ph_d  = 1'b0;
        act_d = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Array port
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_arr;
    mem_wdata = req_wdata;
    unique case (st_q)
      ST_IDLE: if (acc && !hit_buf) begin
        mem_en = 1'b1;
        mem_we = req_write;
      end
      ST_FETCH_B: begin
        mem_en   = 1'b1;
        mem_addr = {tb, ptr_q};
      end
      ST_PUT_A: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {ta, ptr_q};
        mem_wdata = mem_rdata;
      end
      ST_PUT_B: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tb, ptr_q};
        mem_wdata = buf_q;
      end
      ST_FETCH_A: begin
        mem_en   = 1'b1;
        mem_addr = {ta, ptr_q};
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      due_q     <= 1'b0;
      wcnt_q    <= '0;
      act_q     <= 1'b0;
      ph_q      <= 1'b0;
      pa_q      <= '0;
      pb_q      <= '0;
      ptr_q     <= '0;
      buf_q     <= '0;
      rsp_v_q   <= 1'b0;
      rsp_buf_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      due_q     <= due_d;
      wcnt_q    <= wcnt_d;
      act_q     <= act_d;
      ph_q      <= ph_d;
      pa_q      <= pa_d;
      pb_q      <= pb_d;
      ptr_q     <= ptr_d;
      buf_q     <= buf_d;
      rsp_v_q   <= acc && !req_write;
      rsp_buf_q <= acc && hit_buf;
    end
  end
endmodule

// File: rtl/remap_ctrl_chk.sv
module remap_ctrl_chk
  import remap_pkg::*;
#(
  parameter int RW    = 4,
  parameter int CW    = 3,
  parameter int QUOTA = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          mem_en,
  input logic          mem_we,
  input logic [CW-1:0] wcnt_q,
  input logic [RW-1:0] pa_q,
  input logic [RW-1:0] pb_q,
  input logic [15:0]   lfsr_q,
  input step_e         st_q
);
  p_quota_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && wcnt_q == CW'(QUOTA - 1)) |=> !req_ready);

  p_read_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_no_spur_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  p_read_no_quota_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> $stable(wcnt_q));

  p_fetch_then_put_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH_B) |=> (mem_en && mem_we && !req_ready));

  p_pair_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH_B) |-> (pa_q != pb_q));

  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'd0);

  p_lfsr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lfsr_q != $past(lfsr_q)));
endmodule

bind remap_ctrl remap_ctrl_chk #(.RW(RW), .CW(CW), .QUOTA(QUOTA)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .mem_en(mem_en), .mem_we(mem_we),
  .wcnt_q(wcnt_q), .pa_q(pa_q), .pb_q(pb_q), .lfsr_q(lfsr_q), .st_q(st_q)
);

// File: tb/remap_ctrl_test.sv
module remap_ctrl_test;
  localparam int AW  = 7;
  localparam int DW  = 8;
  localparam int N   = 1 << AW;
  localparam int HOT = 43;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  remap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Array model: one-cycle read latency
  logic [DW-1:0] arr [N];
  initial for (int i = 0; i < N; i++) arr[i] = '0;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) arr[mem_addr] <= mem_wdata;
      else        mem_rdata     <= arr[mem_addr];
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;
  int total_writes = 0;
  logic [DW-1:0] shadow [N];
  logic          s_en, s_we;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_rd;
  logic          s_rv, s_rdy;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Stall-window monitor (R4)
  int rn = 0, wn = 0, nwin = 0, stalls = 0;
  bit in_win = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) begin
        in_win = 1;
        stalls++;
        if (mem_en) begin
          if (mem_we) wn++;
          else        rn++;
        end
      end else if (in_win) begin
        check(rn == 1, "R4 reads per stall", rn, 1);
        check(wn == ((nwin == 0) ? 0 : 1), "R4 writes per stall", wn, (nwin == 0) ? 0 : 1);
        nwin++;
        in_win = 0;
        rn = 0;
        wn = 0;
      end
    end
  end

  // Issue one request, called at a falling edge
  task automatic xfer(input bit wr, input int addr, input logic [DW-1:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(addr);
    req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    s_en   = mem_en;
    s_we   = mem_we;
    s_addr = mem_addr;
    @(negedge clk);
    req_valid = 1'b0;
    s_rv  = rsp_valid;
    s_rd  = rsp_rdata;
    s_rdy = req_ready;
    if (wr) begin
      total_writes++;
      shadow[addr] = d;
      check(s_rdy == ((total_writes % 8) != 0), "R3 ready after write",
            s_rdy, (total_writes % 8) != 0);
    end else begin
      check(s_rdy == 1'b1, "R3 ready after read", s_rdy, 1);
    end
  endtask

  task automatic read_check(input int addr, input string req);
    xfer(1'b0, addr, '0);
    check(s_rv == 1'b1, "R5 response valid", s_rv, 1);
    check(s_rd == shadow[addr], req, s_rd, shadow[addr]);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    bit [15:0] seen = '0;
    int st0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_en == 1'b0, "R1 idle array after reset", mem_en, 0);
    check(rsp_valid == 1'b0, "R5 no response without read", rsp_valid, 0);

    // Fill sweep; the first eight writes must be identity-mapped (R1)
    for (int a = 0; a < N; a++) begin
      xfer(1'b1, a, DW'((a * 7 + 3) & 8'hFF));
      if (a < 8) begin
        check(s_en && s_we, "R1 write reaches array", s_en, 1);
        check(s_addr == AW'(a), "R1 identity mapping", s_addr, a);
      end
      check(s_rv == 1'b0, "R5 no response to write", s_rv, 0);
    end

    // Reads only: quota untouched, no stall (R6)
    repeat (12) @(negedge clk);
    st0 = stalls;
    for (int a = 0; a < N; a++) read_check(a, "R2 fill readback");
    check(stalls == st0, "R6 reads never stall", stalls - st0, 0);

    // Hot address hammering
    for (int it = 0; it < 12; it++) begin
      for (int k = 0; k < 1000; k++) begin
        xfer(1'b1, HOT, DW'((it * 31 + k) & 8'hFF));
        if (s_en) seen[s_addr[AW-1:3]] = 1'b1;
        read_check(HOT, "R2 hot readback");
      end
      for (int a = 0; a < N; a++) read_check(a, "R2 sweep after hammering");
    end
    check($countones(seen) >= 4, "R7 hot block array regions",
          $countones(seen), 4);

    repeat (20) @(negedge clk);
    check(nwin == total_writes / 8, "R4 stall count", nwin, total_writes / 8);

    done = 1;
    summary();
    $finish;
  end
endmodule